// File: doc/BRIEF.md
# I2C Register Block Transfer Sequencer

This block drives a byte-level I2C master engine through whole register-block transactions with a slave that has a 7-bit address. The host places data in a small internal byte buffer, then issues one command that names the direction, the slave address, the starting register index and a byte count. The sequencer then issues bus operations to the engine one at a time: start, repeated start, write byte, read byte, and stop. It waits for each one to complete before it issues the next.

A block write sends the address byte in write direction, then the register index, then the buffered bytes, then a stop. A block read first writes the register index in the same way. It then turns the bus around with a repeated start and sends the address byte in read direction. The received bytes go into the buffer, and a stop follows. The host reads the buffer back through a separate index port. The transaction ends with one of three one-cycle result pulses: completion, missing slave acknowledge, or arbitration loss. A length error pulse reports a command that is rejected.

Top module: `i2c_blk_seq`

## Requirements
- R1: The first byte after a start or a repeated start is the 7-bit slave address in bits 7..1 with the direction in bit 0. Bit 0 is 0 for the write phase and 1 for the read phase.
- R2: A write of length L ≥ 1 issues these operations in order: start, the address byte (write), the register index, buffer bytes 0..L-1, and stop. `done` then pulses.
- R3: A read of length L ≥ 1 issues these operations in order: start, the address byte (write), the register index, repeated start, the address byte (read), L read operations, and stop. Received byte i is stored in buffer entry i. `done` then pulses.
- R4: On each read operation `eng_ack_out` is 1 (master acknowledge), except on the last read of the block, where it is 0 (not-acknowledge). The final not-acknowledge is not reported as an error.
- R5: If any written byte completes with `eng_nack` high, no further byte is issued. The next operation is stop, and then `err_nack` pulses instead of `done`.
- R6: If any operation completes with `eng_arb_lost` high, the sequencer issues no further operation, stop included. It returns to idle and `arb_lost` pulses.
- R7: A write of length 0 issues only start, the address byte, the register index, and stop.
- R8: A command whose length exceeds the buffer depth, or a read of length 0, is rejected. `err_len` pulses in the cycle after `cmd_valid`, no bus operation is issued, and `busy` stays low.
- R9: `busy` rises in the cycle after an accepted command and stays high until the result pulse. In the cycle the result pulses, `busy` is low. At most one result pulse is high at a time, and each lasts one cycle.
- R10: Host loads into the buffer (`buf_wr_en`) are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_rd | input | 1 | 1 = block read, 0 = block write |
| cmd_addr | input | 7 | Slave address |
| cmd_reg | input | 8 | Starting register index |
| cmd_len | input | LEN_W | Byte count, 0 to BUF_DEPTH |
| buf_wr_en | input | 1 | Host buffer load strobe |
| buf_wr_idx | input | IDX_W | Host load index |
| buf_wr_data | input | 8 | Host load data |
| buf_rd_idx | input | IDX_W | Host read-back index |
| buf_rd_data | output | 8 | Buffer entry at `buf_rd_idx` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Normal completion pulse |
| err_nack | output | 1 | Missing slave acknowledge pulse |
| err_len | output | 1 | Rejected command pulse |
| arb_lost | output | 1 | Arbitration loss pulse |
| eng_req | output | 1 | One-cycle request for an engine operation |
| eng_op | output | 3 | Operation: 0 start, 1 repeated start, 2 write, 3 read, 4 stop |
| eng_wdata | output | 8 | Byte for a write operation |
| eng_ack_out | output | 1 | For a read: 1 acknowledge, 0 not-acknowledge |
| eng_done | input | 1 | Operation complete |
| eng_nack | input | 1 | Written byte was not acknowledged |
| eng_arb_lost | input | 1 | Arbitration lost during the operation |
| eng_rdata | input | 8 | Received byte for a read operation |

## Verification
The bench builds the block with the default buffer depth of 8, which gives a 4-bit length field. At this depth a full 8-byte block is reachable, and so are the first rejected length (9) and the largest length the field can carry (15). The engine is a bench model with an attached slave register file and a random completion latency of one to three cycles. This latency moves every operation boundary relative to the sequencer's handshake. Injected not-acknowledges on the address byte, the register index and data bytes, and arbitration loss on any operation including stop, cover each abort path at depth 8.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_STOP    = 3'd4
    } bus_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR_W,
        ST_REG,
        ST_WDATA,
        ST_RSTART,
        ST_ADDR_R,
        ST_RDATA,
        ST_STOP
    } seq_state_e;

    typedef struct packed {
        logic       rd;
        logic [6:0] addr;
        logic [7:0] reg_ix;
    } xfer_hdr_t;

    function automatic bus_op_e op_of(seq_state_e s);
        case (s)
            ST_START:  return OP_START;
            ST_RSTART: return OP_RESTART;
            ST_RDATA:  return OP_READ;
            ST_STOP:   return OP_STOP;
            default:   return OP_WRITE;
        endcase
    endfunction

    function automatic logic is_wr_state(seq_state_e s);
        return (s == ST_ADDR_W) || (s == ST_REG) || (s == ST_WDATA) || (s == ST_ADDR_R);
    endfunction

endpackage

// File: rtl/i2c_blk_buf.sv
module i2c_blk_buf #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx_a,
    output logic [7:0]       rdata_a,
    input  logic [IDX_W-1:0] ridx_b,
    output logic [7:0]       rdata_b
);

    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (we && (widx == IDX_W'(g)))
                mem[g] <= wdata;
        end
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];

endmodule

// File: rtl/i2c_blk_ctrl.sv
module i2c_blk_ctrl
    import i2c_blk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LEN_W = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_rd,
    input  logic [6:0]       cmd_addr,
    input  logic [7:0]       cmd_reg,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             busy,
    output logic             done,
    output logic             err_nack,
    output logic             err_len,
    output logic             arb_lost,
    output logic             eng_req,
    output logic [2:0]       eng_op,
    output logic [7:0]       eng_wdata,
    output logic             eng_ack_out,
    input  logic             eng_done,
    input  logic             eng_nack,
    input  logic             eng_arb_lost,
    input  logic [7:0]       eng_rdata,
    output logic [IDX_W-1:0] buf_ridx,
    input  logic [7:0]       buf_rdata,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_widx,
    output logic [7:0]       buf_wdata
);

    seq_state_e       st, nxt;
    xfer_hdr_t        hdr;
    logic [LEN_W-1:0] len;
    logic [IDX_W-1:0] cnt;
    logic             pending;
    logic             nack_seen;
    logic             len_bad, accept, last, step;

    assign len_bad = (cmd_len > LEN_W'(DEPTH)) || (cmd_rd && (cmd_len == '0));
    assign accept  = cmd_valid && (st == ST_IDLE) && !len_bad;
    assign last    = (LEN_W'(cnt) == len - LEN_W'(1));
    assign step    = pending && eng_done;

    assign busy        = (st != ST_IDLE);
    assign eng_req     = busy && !pending;
    assign eng_op      = op_of(st);
    assign eng_ack_out = !last;

    always_comb begin
        case (st)
            ST_ADDR_W: eng_wdata = {hdr.addr, 1'b0};
            ST_ADDR_R: eng_wdata = {hdr.addr, 1'b1};
            ST_REG:    eng_wdata = hdr.reg_ix;
            ST_WDATA:  eng_wdata = buf_rdata;
            default:   eng_wdata = '0;
        endcase
    end

    assign buf_ridx  = cnt;
    assign buf_widx  = cnt;
    assign buf_wdata = eng_rdata;
    assign buf_we    = step && (st == ST_RDATA) && !eng_arb_lost;

    always_comb begin
        nxt = st;
        if (step) begin
            if (eng_arb_lost)
                nxt = ST_IDLE;
            else begin
                case (st)
                    ST_START:  nxt = ST_ADDR_W;
                    ST_ADDR_W: nxt = eng_nack ? ST_STOP : ST_REG;
                    ST_REG: begin
                        if (eng_nack)         nxt = ST_STOP;
                        else if (hdr.rd)      nxt = ST_RSTART;
                        else if (len == '0)   nxt = ST_STOP;
                        else                  nxt = ST_WDATA;
                    end
                    ST_WDATA:  nxt = (eng_nack || last) ? ST_STOP : ST_WDATA;
                    ST_RSTART: nxt = ST_ADDR_R;
                    ST_ADDR_R: nxt = eng_nack ? ST_STOP : ST_RDATA;
                    ST_RDATA:  nxt = last ? ST_STOP : ST_RDATA;
                    ST_STOP:   nxt = ST_IDLE;
                    default:   nxt = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            hdr       <= '0;
            len       <= '0;
            cnt       <= '0;
            pending   <= 1'b0;
            nack_seen <= 1'b0;
            done      <= 1'b0;
            err_nack  <= 1'b0;
            err_len   <= 1'b0;
            arb_lost  <= 1'b0;
        end else begin
            done     <= 1'b0;
            err_nack <= 1'b0;
            arb_lost <= 1'b0;
            err_len  <= cmd_valid && (st == ST_IDLE) && len_bad;
            if (accept) begin
                hdr       <= '{rd: cmd_rd, addr: cmd_addr, reg_ix: cmd_reg};
                len       <= cmd_len;
                cnt       <= '0;
                nack_seen <= 1'b0;
                st        <= ST_START;
            end else begin
                if (eng_req)
                    pending <= 1'b1;
                if (step) begin
                    pending <= 1'b0;
                    st      <= nxt;
                    if (eng_arb_lost)
                        arb_lost <= 1'b1;
                    else begin
                        if (st == ST_STOP) begin
                            done     <= !nack_seen;
                            err_nack <= nack_seen;
                        end
                        if (is_wr_state(st) && eng_nack)
                            nack_seen <= 1'b1;
                        if ((st == ST_WDATA || st == ST_RDATA) && !last)
                            cnt <= cnt + 1'b1;
                        else if (st == ST_REG || st == ST_ADDR_R)
                            cnt <= '0;
                    end
                end
            end
        end
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        $countones({done, err_nack, err_len, arb_lost}) <= 1);                       // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                             // R9
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eng_req |=> !eng_req);                                                       // R2
    AST_NACK_STOP: assert property (@(posedge clk) disable iff (rst)
        (step && !eng_arb_lost && eng_nack && is_wr_state(st)) |=> (eng_req && eng_op == 3'd4)); // R5
    AST_ARB_QUIET: assert property (@(posedge clk) disable iff (rst)
        (step && eng_arb_lost) |=> (!eng_req && !busy && arb_lost));                 // R6
    AST_LEN_REJECT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && len_bad) |=> (err_len && !busy));                     // R8

endmodule

// File: rtl/i2c_blk_seq.sv
module i2c_blk_seq #(
    parameter int BUF_DEPTH = 8,
    localparam int LEN_W = $clog2(BUF_DEPTH + 1),
    localparam int IDX_W = $clog2(BUF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_rd,
    input  logic [6:0]       cmd_addr,
    input  logic [7:0]       cmd_reg,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             buf_wr_en,
    input  logic [IDX_W-1:0] buf_wr_idx,
    input  logic [7:0]       buf_wr_data,
    input  logic [IDX_W-1:0] buf_rd_idx,
    output logic [7:0]       buf_rd_data,
    output logic             busy,
    output logic             done,
    output logic             err_nack,
    output logic             err_len,
    output logic             arb_lost,
    output logic             eng_req,
    output logic [2:0]       eng_op,
    output logic [7:0]       eng_wdata,
    output logic             eng_ack_out,
    input  logic             eng_done,
    input  logic             eng_nack,
    input  logic             eng_arb_lost,
    input  logic [7:0]       eng_rdata
);

    logic             f_we;
    logic [IDX_W-1:0] f_widx, f_ridx;
    logic [7:0]       f_wdata, f_rdata;
    logic             m_we;
    logic [IDX_W-1:0] m_widx;
    logic [7:0]       m_wdata;

    assign m_we    = busy ? f_we : buf_wr_en;
    assign m_widx  = busy ? f_widx : buf_wr_idx;
    assign m_wdata = busy ? f_wdata : buf_wr_data;

    i2c_blk_buf #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst(rst),
        .we(m_we), .widx(m_widx), .wdata(m_wdata),
        .ridx_a(buf_rd_idx), .rdata_a(buf_rd_data),
        .ridx_b(f_ridx), .rdata_b(f_rdata)
    );

    i2c_blk_ctrl #(.DEPTH(BUF_DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
        .cmd_reg(cmd_reg), .cmd_len(cmd_len),
        .busy(busy), .done(done), .err_nack(err_nack), .err_len(err_len),
        .arb_lost(arb_lost),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_ack_out(eng_ack_out), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_arb_lost(eng_arb_lost), .eng_rdata(eng_rdata),
        .buf_ridx(f_ridx), .buf_rdata(f_rdata),
        .buf_we(f_we), .buf_widx(f_widx), .buf_wdata(f_wdata)
    );

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_len != '0 && cmd_len <= LEN_W'(BUF_DEPTH)) |=> busy); // R9
    AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && buf_wr_en && !f_we) |=> $stable(busy));                               // R10

endmodule

// File: tb/i2c_blk_seq_bench.sv
module i2c_blk_seq_bench;

    localparam int DEPTH = 8;
    localparam int LW = 4;
    localparam int IW = 3;
    localparam logic [6:0] SLV = 7'h1D;
    localparam logic [2:0] K_ST = 3'd0, K_RS = 3'd1, K_WR = 3'd2, K_RD = 3'd3, K_SP = 3'd4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          cmd_valid = 0, cmd_rd = 0;
    logic [6:0]    cmd_addr = 0;
    logic [7:0]    cmd_reg = 0;
    logic [LW-1:0] cmd_len = 0;
    logic          buf_wr_en = 0;
    logic [IW-1:0] buf_wr_idx = 0, buf_rd_idx = 0;
    logic [7:0]    buf_wr_data = 0, buf_rd_data;
    logic          busy, done, err_nack, err_len, arb_lost;
    logic          eng_req, eng_ack_out;
    logic [2:0]    eng_op;
    logic [7:0]    eng_wdata;
    logic          eng_done = 0, eng_nack = 0, eng_arb_lost = 0;
    logic [7:0]    eng_rdata = 0;

    i2c_blk_seq #(.BUF_DEPTH(DEPTH)) u_i2c_blk_seq (.*);

    int n_chk = 0, n_bad = 0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // engine + slave model
    logic [7:0] sl_mem [256];
    logic [2:0] lg_op [64];
    logic [7:0] lg_dat [64];
    int lg_n = 0, arb_at = -1, nack_at = -1, wcnt = 0;
    int e_busy = 0, e_cnt = 0, sl_bc = 0;
    logic sl_dir = 0, sl_match = 0;
    logic [7:0] sl_ptr = 0;
    logic [2:0] l_op;
    logic [7:0] l_wd;
    logic l_ack;

    always @(negedge clk) begin
        if (eng_done) begin
            eng_done = 0; eng_nack = 0; eng_arb_lost = 0; e_busy = 0;
        end
        if (e_busy == 0 && eng_req && !rst) begin
            e_busy = 1; l_op = eng_op; l_wd = eng_wdata; l_ack = eng_ack_out;
            e_cnt = $urandom_range(0, 2);
        end else if (e_busy == 1) begin
            if (e_cnt > 0) e_cnt--;
            else begin
                lg_op[lg_n] = l_op;
                lg_dat[lg_n] = (l_op == K_WR) ? l_wd : (l_op == K_RD) ? {7'd0, l_ack} : 8'd0;
                eng_done = 1;
                if (lg_n == arb_at) eng_arb_lost = 1;
                else begin
                    case (l_op)
                        K_ST, K_RS: sl_bc = 0;
                        K_WR: begin
                            if (sl_bc == 0) begin
                                sl_match = (l_wd[7:1] == SLV); sl_dir = l_wd[0];
                                eng_nack = !sl_match;
                            end else begin
                                eng_nack = !sl_match;
                                if (sl_match && wcnt != nack_at) begin
                                    if (sl_bc == 1) sl_ptr = l_wd;
                                    else begin sl_mem[sl_ptr] = l_wd; sl_ptr++; end
                                end
                            end
                            if (wcnt == nack_at) eng_nack = 1;
                            wcnt++; sl_bc++;
                        end
                        K_RD: begin eng_rdata = sl_mem[sl_ptr]; sl_ptr++; end
                        default: ;
                    endcase
                end
                lg_n++;
                e_busy = 2;
            end
        end
    end

    // expected trace
    logic [2:0] x_op [64];
    logic [7:0] x_dat [64];
    int x_n, x_wb, x_out;
    logic x_ab, x_nk;
    logic [7:0] wdat [DEPTH];

    task automatic push(input logic [2:0] op, input logic [7:0] d);
        if (!x_ab) begin
            x_op[x_n] = op; x_dat[x_n] = d;
            if (x_n == arb_at) x_ab = 1;
            x_n++;
        end
    endtask
    task automatic push_o(input logic [2:0] op, input logic [7:0] d);
        if (!x_ab && !x_nk) push(op, d);
    endtask
    task automatic push_w(input logic [7:0] d);
        if (!x_ab && !x_nk) begin
            push(K_WR, d);
            if (!x_ab && x_wb == nack_at) x_nk = 1;
            x_wb++;
        end
    endtask

    task automatic build(input logic rd, input logic [6:0] a, input logic [7:0] r, input int len);
        x_n = 0; x_wb = 0; x_ab = 0; x_nk = 0;
        push_o(K_ST, 0);
        push_w({a, 1'b0});
        push_w(r);
        if (rd) begin
            push_o(K_RS, 0);
            push_w({a, 1'b1});
            for (int i = 0; i < len; i++) push_o(K_RD, (i == len - 1) ? 8'd0 : 8'd1);
        end else
            for (int i = 0; i < len; i++) push_w(wdat[i]);
        push(K_SP, 0);
        x_out = x_ab ? 2 : x_nk ? 1 : 0;
    endtask

    task automatic run(input logic rd, input logic [6:0] a, input logic [7:0] r, input int len,
                       input int nk, input int ab, input logic poke);
        logic [7:0] snap [DEPTH];
        int t;
        int firstbad;
        arb_at = ab; nack_at = (a != SLV) ? 0 : nk; lg_n = 0; wcnt = 0;
        for (int i = 0; i < DEPTH; i++) snap[i] = sl_mem[8'(r + i)];
        if (!rd) for (int i = 0; i < len; i++) begin
            wdat[i] = 8'($urandom);
            @(negedge clk); buf_wr_en = 1; buf_wr_idx = IW'(i); buf_wr_data = wdat[i];
        end
        build(rd, a, r, len);
        @(negedge clk);
        buf_wr_en = 0; cmd_valid = 1; cmd_rd = rd; cmd_addr = a; cmd_reg = r; cmd_len = LW'(len);
        @(negedge clk);
        cmd_valid = 0;
        check(busy == 1, "R9 busy after accept", busy, 1);
        if (poke) begin
            buf_wr_en = 1; buf_wr_idx = 0; buf_wr_data = ~wdat[0];
            @(negedge clk); buf_wr_en = 0;
        end
        t = 0;
        while (!(done || err_nack || arb_lost) && t < 500) begin
            check(busy == 1, "R9 busy held", busy, 1);
            @(negedge clk); t++;
        end
        check(t < 500, "R9 result timeout", t, 0);
        check(busy == 0, "R9 busy low at result", busy, 0);
        check({arb_lost, err_nack, done} == 3'(1 << x_out),
              x_out == 2 ? "R6 outcome" : x_out == 1 ? "R5 outcome" : rd ? "R3 outcome" : "R2 outcome",
              {arb_lost, err_nack, done}, 1 << x_out);
        @(negedge clk);
        check({arb_lost, err_nack, done, err_len} == 0, "R9 single-cycle pulse",
              {arb_lost, err_nack, done, err_len}, 0);
        firstbad = -1;
        for (int i = 0; i < x_n; i++)
            if (i >= lg_n || lg_op[i] != x_op[i] || lg_dat[i] != x_dat[i])
                if (firstbad < 0) firstbad = i;
        check(lg_n == x_n && firstbad < 0,
              len == 0 && !rd ? "R7 trace" : rd ? "R3 trace" : "R2 trace",
              (firstbad < 0) ? lg_n : {lg_op[firstbad], lg_dat[firstbad]},
              (firstbad < 0) ? x_n : {x_op[firstbad], x_dat[firstbad]});
        if (lg_n > 1) check(lg_dat[1] == {a, 1'b0}, "R1 write address byte", lg_dat[1], {a, 1'b0});
        if (rd && x_out == 0) begin
            check(lg_dat[4] == {a, 1'b1}, "R1 read address byte", lg_dat[4], {a, 1'b1});
            check(lg_dat[4 + len] == 0, "R4 last read nack", lg_dat[4 + len], 0);
            if (len > 1) check(lg_dat[5] == 1, "R4 first read ack", lg_dat[5], 1);
            for (int i = 0; i < len; i++) begin
                buf_rd_idx = IW'(i); #1;
                check(buf_rd_data == snap[i], "R3 buffer data", buf_rd_data, snap[i]);
            end
        end
        if (poke) begin
            buf_rd_idx = 0; #1;
            check(buf_rd_data == wdat[0], "R10 load ignored", buf_rd_data, wdat[0]);
        end
    endtask

    task automatic reject(input logic rd, input int len);
        lg_n = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_rd = rd; cmd_addr = SLV; cmd_reg = 8'h10; cmd_len = LW'(len);
        @(negedge clk);
        cmd_valid = 0;
        check(err_len == 1, "R8 err_len pulse", err_len, 1);
        check(busy == 0, "R8 busy stays low", busy, 0);
        @(negedge clk);
        check(err_len == 0, "R8 pulse ends", err_len, 0);
        repeat (4) @(negedge clk);
        check(lg_n == 0 && busy == 0, "R8 no bus op", lg_n, 0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 256; i++) sl_mem[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check({busy, done, err_nack, err_len, arb_lost, eng_req} == 0, "R9 reset state",
              {busy, done, err_nack, err_len, arb_lost, eng_req}, 0);
        // directed corners
        run(0, SLV, 8'h20, 3, -1, -1, 0);   // R2
        run(1, SLV, 8'h20, 3, -1, -1, 0);   // R3 read back written data
        run(0, SLV, 8'h40, 0, -1, -1, 0);   // R7
        run(1, SLV, 8'hFC, 8, -1, -1, 0);   // R3 full depth, pointer wrap
        run(1, SLV, 8'h05, 1, -1, -1, 0);   // R4 single byte nack
        run(0, 7'h22, 8'h10, 4, -1, -1, 0); // R5 address nack
        run(0, SLV, 8'h10, 4, 1, -1, 0);    // R5 register nack
        run(0, SLV, 8'h10, 5, 4, -1, 0);    // R5 data nack
        run(1, SLV, 8'h10, 4, 2, -1, 0);    // R5 read address nack
        run(0, SLV, 8'h30, 3, -1, 3, 0);    // R6 mid write
        run(1, SLV, 8'h30, 3, -1, 8, 0);    // R6 on stop
        run(1, SLV, 8'h30, 2, -1, 0, 0);    // R6 on start
        run(0, SLV, 8'h50, 4, -1, -1, 1);   // R10
        reject(1, 0);                       // R8
        reject(0, 9);                       // R8
        reject(1, 15);                      // R8
        // constrained random
        for (int k = 0; k < 60; k++) begin
            logic rd;
            int len, nk, ab, sel;
            rd = 1'($urandom);
            len = rd ? $urandom_range(1, DEPTH) : $urandom_range(0, DEPTH);
            sel = $urandom_range(0, 9);
            nk = (sel == 0) ? $urandom_range(0, 3) : -1;
            ab = (sel == 1) ? $urandom_range(0, 6) : -1;
            run(rd, (sel == 2) ? 7'h2A : SLV, 8'($urandom), len, nk, ab, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule